// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This unit performs the architectural side of taking an exception in a 32-bit core with a coprocessor-0 style control state. When the pipeline raises a request, the unit classifies it as an ordinary exception, an interrupt, a reset-class event (cold reset, soft reset, non-maskable interrupt) or a debug event. It then saves the corrected resume address into the matching save register, updates the cause and status fields, and produces the address of the handler to fetch from next.

The current exception-level, error-level and boot-vector status bits are owned by the status register outside this unit. They arrive as inputs with the request, and the unit returns their new values. The unit itself holds the saved PCs, the branch-delay flag, the exception code, the coprocessor number, the soft-reset and NMI flags, debug mode and the debug cause bits. Each accepted request produces a one-cycle `done_o` pulse. All results are registered and become valid in the same cycle as that pulse.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `done_o`, `handler_pc_o`, all three saved PCs, `bd_o`, `exccode_o`, `ce_o`, every status output, `kernel_o`, `debug_mode_o` and `dbg_cause_o` are zero.
- R2: An ordinary exception (`kind_i` 0, or any code 11..15) or an interrupt (`kind_i` 1) with `exl_i`=0 writes the resume PC to `epc_o` and `bd_i` to `bd_o`. Any such entry drives `exl_o`=1 and `kernel_o`=1, and passes `erl_i` and `bev_i` through to `erl_o` and `bev_o`.
- R3: The resume PC equals `pc_i` when `bd_i`=0. When `bd_i`=1 it is `pc_i`-4, or `pc_i`-2 if `bd16_i`=1.
- R4: An ordinary exception or interrupt taken with `exl_i`=1 leaves `epc_o` and `bd_o` unchanged but still updates `exccode_o`.
- R5: For ordinary entries the handler base is 0xBFC00200 when `bev_i`=1, and `ebase_i` with bits 9:0 cleared otherwise. The general offset is 0x180.
- R6: With `refill_i`=1 on an ordinary exception, the offset is 0x000 when `exl_i`=0 and 0x180 when `exl_i`=1.
- R7: An interrupt writes exccode 0. Its offset is 0x180 when `iv_i`=0. When `iv_i`=1 the offset is 0x200, except when `vint_en_i`=1 and `vs_i`≠0: then it is 0x200 + n·`vs_i`·32, where n is the index of the highest set bit of `ip_i` (0 if none is set).
- R8: An ordinary exception writes `exc_code_i` to `exccode_o`. When that code is 11 (coprocessor unusable), `ce_i` is written to `ce_o`; for any other code `ce_o` keeps its value.
- R9: Cold reset (`kind_i` 2), soft reset (3) and NMI (4) write the resume PC to `errorepc_o`, drive `erl_o`=1, `bev_o`=1 and `exl_o`=`exl_i`, clear `bd_o` if `exl_i`=0, and jump to 0xBFC00000. `sr_o` becomes 1 only for soft reset and `nmi_o` becomes 1 only for NMI; otherwise each becomes 0.
- R10: Debug kinds 5..10 (single step, debug interrupt, instruction break, break instruction, data break store, data break load) set `dbg_cause_o` bit (`kind_i`-5) in addition to the bits already set. They set `debug_mode_o` (sticky until reset), write the resume PC to `depc_o` and jump to 0xBFC00480. Single step saves `pc_i` without the delay-slot correction. `epc_o` is unchanged, and `bd_o` is cleared if `exl_i`=0.
- R11: `done_o` is high exactly in the cycle after a cycle with `req_i`=1. Without a request, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request strobe |
| kind_i | input | 4 | Request kind code (see R2, R9, R10) |
| exc_code_i | input | 5 | Exception code for ordinary exceptions |
| ce_i | input | 2 | Coprocessor number for code 11 |
| pc_i | input | 32 | PC of the excepting instruction |
| bd_i | input | 1 | Instruction sits in a branch delay slot |
| bd16_i | input | 1 | Branch preceding the slot is 16-bit encoded |
| refill_i | input | 1 | Exception is a TLB refill miss |
| exl_i | input | 1 | Current exception-level bit |
| erl_i | input | 1 | Current error-level bit |
| bev_i | input | 1 | Current boot-vector bit |
| ebase_i | input | 32 | Exception base register |
| iv_i | input | 1 | Interrupts use the dedicated vector |
| vint_en_i | input | 1 | Vectored interrupt mode enabled |
| vs_i | input | 5 | Vector spacing field, units of 32 bytes |
| ip_i | input | 8 | Pending interrupt lines |
| done_o | output | 1 | Entry completed, results valid |
| handler_pc_o | output | 32 | Handler fetch address |
| epc_o | output | 32 | Saved PC for ordinary exceptions |
| errorepc_o | output | 32 | Saved PC for reset-class events |
| depc_o | output | 32 | Saved PC for debug events |
| bd_o | output | 1 | Branch-delay flag of the cause register |
| exccode_o | output | 5 | Exception code of the cause register |
| ce_o | output | 2 | Coprocessor number of the cause register |
| exl_o | output | 1 | New exception-level bit |
| erl_o | output | 1 | New error-level bit |
| bev_o | output | 1 | New boot-vector bit |
| sr_o | output | 1 | Soft-reset status flag |
| nmi_o | output | 1 | NMI status flag |
| kernel_o | output | 1 | Kernel mode forced by entry |
| debug_mode_o | output | 1 | Debug mode active |
| dbg_cause_o | output | 6 | Accumulated debug cause bits |

## Verification
The hardest case to reach from the ports is an exception nested under `exl_i`=1. There the saved PC and delay flag must survive while the code, vector and refill offset still change. The stimulus first takes a delay-slot exception with EXL clear, so that `epc_o` and `bd_o` hold distinctive values. It then raises further exceptions with EXL set, including a refill, and checks that those fields stay put. Vectored interrupts are driven with several pending-line patterns, including an empty one and the largest spacing, so that the priority choice and the offset arithmetic are both exposed.

// File: rtl/eeu_pkg.sv
package eeu_pkg;
  typedef enum logic [3:0] {
    K_GEN  = 4'd0,
    K_INT  = 4'd1,
    K_COLD = 4'd2,
    K_SOFT = 4'd3,
    K_NMI  = 4'd4,
    K_DSS  = 4'd5,
    K_DINT = 4'd6,
    K_DIB  = 4'd7,
    K_DBP  = 4'd8,
    K_DDBS = 4'd9,
    K_DDBL = 4'd10
  } kind_e;

  typedef enum logic [1:0] {
    C_EXC = 2'd0,
    C_RST = 2'd1,
    C_DBG = 2'd2
  } class_e;

  localparam int unsigned DBG_CAUSE_W = 6;
  localparam logic [4:0]  CODE_CPU    = 5'd11;
  localparam logic [4:0]  CODE_INT    = 5'd0;

  function automatic class_e classify(input logic [3:0] k);
    if (k >= K_DSS && k <= K_DDBL)      return C_DBG;
    else if (k >= K_COLD && k <= K_NMI) return C_RST;
    else                                return C_EXC;
  endfunction
endpackage

// File: rtl/eeu_resume_pc.sv
module eeu_resume_pc #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            bd_i,
  input  logic            bd16_i,
  output logic [XLEN-1:0] resume_o
);
  localparam logic [XLEN-1:0] STEP_WORD = XLEN'(4);
  localparam logic [XLEN-1:0] STEP_HALF = XLEN'(2);

  always_comb begin
    if (bd_i) resume_o = pc_i - (bd16_i ? STEP_HALF : STEP_WORD);
    else      resume_o = pc_i;
  end
endmodule

// File: rtl/eeu_prio_enc.sv
module eeu_prio_enc #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o
);
  // highest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/eeu_vector.sv
module eeu_vector
  import eeu_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     IP_W          = 8,
  parameter int unsigned     VS_W          = 5,
  parameter int unsigned     OFS_W         = 16,
  parameter int unsigned     EBASE_LSB     = 10,
  parameter int unsigned     SPACING_SHIFT = 5,
  parameter logic [XLEN-1:0] BOOT_BASE     = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] RST_VEC       = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC       = 32'hBFC0_0480,
  parameter int unsigned     REFILL_OFS    = 'h000,
  parameter int unsigned     GEN_OFS       = 'h180,
  parameter int unsigned     INT_OFS       = 'h200
) (
  input  class_e          cls_i,
  input  logic            is_int_i,
  input  logic            refill_i,
  input  logic            exl_i,
  input  logic            bev_i,
  input  logic [XLEN-1:0] ebase_i,
  input  logic            iv_i,
  input  logic            vint_en_i,
  input  logic [VS_W-1:0] vs_i,
  input  logic [IP_W-1:0] ip_i,
  output logic [XLEN-1:0] pc_o
);
  localparam int unsigned     IDX_W      = (IP_W > 1) ? $clog2(IP_W) : 1;
  localparam logic [XLEN-1:0] EBASE_MASK = ~((XLEN'(1) << EBASE_LSB) - XLEN'(1));

  logic [IDX_W-1:0] irq_idx;
  logic [OFS_W-1:0] spacing;
  logic [OFS_W-1:0] offset;
  logic [XLEN-1:0]  base;

  eeu_prio_enc #(.N(IP_W)) u_prio (
    .req_i (ip_i),
    .idx_o (irq_idx)
  );

  assign spacing = OFS_W'(vs_i) << SPACING_SHIFT;
  assign base    = bev_i ? BOOT_BASE : (ebase_i & EBASE_MASK);

  always_comb begin
    if (is_int_i) begin
      if (!iv_i)
        offset = OFS_W'(GEN_OFS);
      else if (vint_en_i && (vs_i != '0))
        offset = OFS_W'(INT_OFS) + OFS_W'(irq_idx) * spacing;
      else
        offset = OFS_W'(INT_OFS);
    end else if (refill_i && !exl_i) begin
      offset = OFS_W'(REFILL_OFS);
    end else begin
      offset = OFS_W'(GEN_OFS);
    end
  end

  always_comb begin
    unique case (cls_i)
      C_RST:   pc_o = RST_VEC;
      C_DBG:   pc_o = DBG_VEC;
      default: pc_o = base + XLEN'(offset);
    endcase
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import eeu_pkg::*;
#(
  parameter int unsigned     XLEN    = 32,
  parameter int unsigned     IP_W    = 8,
  parameter int unsigned     VS_W    = 5,
  parameter logic [XLEN-1:0] RST_VEC = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC = 32'hBFC0_0480
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [3:0]             kind_i,
  input  logic [4:0]             exc_code_i,
  input  logic [1:0]             ce_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic                   bd_i,
  input  logic                   bd16_i,
  input  logic                   refill_i,
  input  logic                   exl_i,
  input  logic                   erl_i,
  input  logic                   bev_i,
  input  logic [XLEN-1:0]        ebase_i,
  input  logic                   iv_i,
  input  logic                   vint_en_i,
  input  logic [VS_W-1:0]        vs_i,
  input  logic [IP_W-1:0]        ip_i,
  output logic                   done_o,
  output logic [XLEN-1:0]        handler_pc_o,
  output logic [XLEN-1:0]        epc_o,
  output logic [XLEN-1:0]        errorepc_o,
  output logic [XLEN-1:0]        depc_o,
  output logic                   bd_o,
  output logic [4:0]             exccode_o,
  output logic [1:0]             ce_o,
  output logic                   exl_o,
  output logic                   erl_o,
  output logic                   bev_o,
  output logic                   sr_o,
  output logic                   nmi_o,
  output logic                   kernel_o,
  output logic                   debug_mode_o,
  output logic [DBG_CAUSE_W-1:0] dbg_cause_o
);
  class_e          cls;
  logic            is_int;
  logic            bd_eff;
  logic [XLEN-1:0] resume_pc;
  logic [XLEN-1:0] vec_pc;
  logic [DBG_CAUSE_W-1:0] dbg_bit;

  assign cls     = classify(kind_i);
  assign is_int  = (kind_i == K_INT);
  // single step resumes at the stepped PC, never corrected
  assign bd_eff  = bd_i && (kind_i != K_DSS);
  assign dbg_bit = DBG_CAUSE_W'(1) << (kind_i - 4'(K_DSS));

  eeu_resume_pc #(.XLEN(XLEN)) u_resume (
    .pc_i     (pc_i),
    .bd_i     (bd_eff),
    .bd16_i   (bd16_i),
    .resume_o (resume_pc)
  );

  eeu_vector #(
    .XLEN    (XLEN),
    .IP_W    (IP_W),
    .VS_W    (VS_W),
    .RST_VEC (RST_VEC),
    .DBG_VEC (DBG_VEC)
  ) u_vector (
    .cls_i     (cls),
    .is_int_i  (is_int),
    .refill_i  (refill_i),
    .exl_i     (exl_i),
    .bev_i     (bev_i),
    .ebase_i   (ebase_i),
    .iv_i      (iv_i),
    .vint_en_i (vint_en_i),
    .vs_i      (vs_i),
    .ip_i      (ip_i),
    .pc_o      (vec_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      handler_pc_o <= '0;
      epc_o        <= '0;
      errorepc_o   <= '0;
      depc_o       <= '0;
      bd_o         <= 1'b0;
      exccode_o    <= '0;
      ce_o         <= '0;
      exl_o        <= 1'b0;
      erl_o        <= 1'b0;
      bev_o        <= 1'b0;
      sr_o         <= 1'b0;
      nmi_o        <= 1'b0;
      kernel_o     <= 1'b0;
      debug_mode_o <= 1'b0;
      dbg_cause_o  <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        handler_pc_o <= vec_pc;
        kernel_o     <= 1'b1;
        unique case (cls)
          C_RST: begin
            errorepc_o <= resume_pc;
            erl_o      <= 1'b1;
            bev_o      <= 1'b1;
            exl_o      <= exl_i;
            sr_o       <= (kind_i == K_SOFT);
            nmi_o      <= (kind_i == K_NMI);
            if (!exl_i) bd_o <= 1'b0;
          end
          C_DBG: begin
            depc_o       <= resume_pc;
            debug_mode_o <= 1'b1;
            dbg_cause_o  <= dbg_cause_o | dbg_bit;
            exl_o        <= exl_i;
            erl_o        <= erl_i;
            bev_o        <= bev_i;
            if (!exl_i) bd_o <= 1'b0;
          end
          default: begin
            if (!exl_i) begin
              epc_o <= resume_pc;
              bd_o  <= bd_i;
            end
            exl_o     <= 1'b1;
            erl_o     <= erl_i;
            bev_o     <= bev_i;
            exccode_o <= is_int ? CODE_INT : exc_code_i;
            if (!is_int && exc_code_i == CODE_CPU) ce_o <= ce_i;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/eeu_checker.sv
module eeu_checker #(
  parameter int unsigned     XLEN    = 32,
  parameter logic [XLEN-1:0] RST_VEC = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DBG_VEC = 32'hBFC0_0480
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [3:0]      kind_i,
  input logic            exl_i,
  input logic            done_o,
  input logic [XLEN-1:0] handler_pc_o,
  input logic [XLEN-1:0] epc_o,
  input logic            bd_o,
  input logic            exl_o,
  input logic            erl_o,
  input logic            bev_o,
  input logic            kernel_o,
  input logic            debug_mode_o
);
  logic is_ord, is_rst, is_dbg;
  assign is_ord = (kind_i <= 4'd1) || (kind_i >= 4'd11);
  assign is_rst = (kind_i >= 4'd2) && (kind_i <= 4'd4);
  assign is_dbg = (kind_i >= 4'd5) && (kind_i <= 4'd10);

  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!done_o && $stable(handler_pc_o) && $stable(epc_o))); // R11
  AST_EPC_HELD_EXL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_ord && exl_i) |=> ($stable(epc_o) && $stable(bd_o))); // R4
  AST_ORD_SETS_EXL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_ord) |=> (exl_o && kernel_o)); // R2
  AST_RESET_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_rst) |=> (handler_pc_o == RST_VEC && erl_o && bev_o)); // R9
  AST_DEBUG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_dbg) |=> (handler_pc_o == DBG_VEC && debug_mode_o)); // R10
  AST_DEBUG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_mode_o |=> debug_mode_o); // R10
  AST_DEBUG_EPC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_dbg) |=> $stable(epc_o)); // R10
endmodule

bind exc_entry_unit eeu_checker #(
  .XLEN    (XLEN),
  .RST_VEC (RST_VEC),
  .DBG_VEC (DBG_VEC)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .kind_i       (kind_i),
  .exl_i        (exl_i),
  .done_o       (done_o),
  .handler_pc_o (handler_pc_o),
  .epc_o        (epc_o),
  .bd_o         (bd_o),
  .exl_o        (exl_o),
  .erl_o        (erl_o),
  .bev_o        (bev_o),
  .kernel_o     (kernel_o),
  .debug_mode_o (debug_mode_o)
);

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  kind = '0;
  logic [4:0]  code = '0;
  logic [1:0]  ce = '0;
  logic [31:0] pc = '0, ebase = '0;
  logic        bd = 0, bd16 = 0, refill = 0, exl = 0, erl = 0, bev = 0;
  logic        iv = 0, ven = 0;
  logic [4:0]  vs = '0;
  logic [7:0]  ip = '0;

  logic        done_o, bd_o, exl_o, erl_o, bev_o, sr_o, nmi_o, kernel_o, dm_o;
  logic [31:0] hpc_o, epc_o, eepc_o, depc_o;
  logic [4:0]  code_o;
  logic [1:0]  ce_o;
  logic [5:0]  dc_o;

  always #2.5 clk = ~clk;

  exc_entry_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .exc_code_i(code),
    .ce_i(ce), .pc_i(pc), .bd_i(bd), .bd16_i(bd16), .refill_i(refill),
    .exl_i(exl), .erl_i(erl), .bev_i(bev), .ebase_i(ebase), .iv_i(iv),
    .vint_en_i(ven), .vs_i(vs), .ip_i(ip), .done_o(done_o),
    .handler_pc_o(hpc_o), .epc_o(epc_o), .errorepc_o(eepc_o), .depc_o(depc_o),
    .bd_o(bd_o), .exccode_o(code_o), .ce_o(ce_o), .exl_o(exl_o), .erl_o(erl_o),
    .bev_o(bev_o), .sr_o(sr_o), .nmi_o(nmi_o), .kernel_o(kernel_o),
    .debug_mode_o(dm_o), .dbg_cause_o(dc_o)
  );

  typedef struct {
    logic [31:0] hpc, epc, eepc, depc;
    logic        bd;
    logic [4:0]  code;
    logic [1:0]  ce;
    logic        exl, erl, bev, sr, nmi, dm;
    logic [5:0]  dc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  // reference state
  logic [31:0] m_epc = '0, m_eepc = '0, m_depc = '0;
  logic        m_bd = 0, m_sr = 0, m_nmi = 0, m_dm = 0;
  logic [4:0]  m_code = '0;
  logic [1:0]  m_ce = '0;
  logic [5:0]  m_dc = '0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] k, input logic [4:0] c, input logic [1:0] cn,
                      input logic [31:0] p, input logic b, input logic b16,
                      input logic rf, input logic x, input logic er, input logic bv,
                      input logic [31:0] eb, input logic v, input logic ve,
                      input logic [4:0] s, input logic [7:0] pend, input string tag);
    exp_t        e;
    logic [31:0] res, base, ofs;
    int          n;
    @(negedge clk);
    res = b ? p - (b16 ? 32'd2 : 32'd4) : p;
    e.exl = x; e.erl = er; e.bev = bv;
    if (k >= 4'd5 && k <= 4'd10) begin
      m_depc = (k == 4'd5) ? p : res;
      if (!x) m_bd = 1'b0;
      m_dm = 1'b1;
      m_dc = m_dc | (6'd1 << (k - 4'd5));
      e.hpc = 32'hBFC0_0480;
    end else if (k >= 4'd2 && k <= 4'd4) begin
      m_eepc = res;
      if (!x) m_bd = 1'b0;
      m_sr = (k == 4'd3);
      m_nmi = (k == 4'd4);
      e.erl = 1'b1; e.bev = 1'b1;
      e.hpc = 32'hBFC0_0000;
    end else begin
      if (!x) begin m_epc = res; m_bd = b; end
      m_code = (k == 4'd1) ? 5'd0 : c;
      if (k != 4'd1 && c == 5'd11) m_ce = cn;
      e.exl = 1'b1;
      base = bv ? 32'hBFC0_0200 : {eb[31:10], 10'b0};
      if (k == 4'd1) begin
        if (!v) ofs = 32'h180;
        else if (ve && s != 0) begin
          n = 0;
          for (int i = 0; i < 8; i++) if (pend[i]) n = i;
          ofs = 32'h200 + 32'(n) * 32'(s) * 32;
        end else ofs = 32'h200;
      end else ofs = (rf && !x) ? 32'h0 : 32'h180;
      e.hpc = base + ofs;
    end
    e.epc = m_epc; e.eepc = m_eepc; e.depc = m_depc; e.bd = m_bd;
    e.code = m_code; e.ce = m_ce; e.sr = m_sr; e.nmi = m_nmi;
    e.dm = m_dm; e.dc = m_dc; e.tag = tag;
    q.push_back(e);
    kind = k; code = c; ce = cn; pc = p; bd = b; bd16 = b16; refill = rf;
    exl = x; erl = er; bev = bv; ebase = eb; iv = v; ven = ve; vs = s; ip = pend;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q.size() == 0) begin
        chk("R11", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "handler", hpc_o, e.hpc);
        chk(e.tag, "epc", epc_o, e.epc);
        chk(e.tag, "errorepc", eepc_o, e.eepc);
        chk(e.tag, "depc", depc_o, e.depc);
        chk(e.tag, "bd", 32'(bd_o), 32'(e.bd));
        chk(e.tag, "exccode", 32'(code_o), 32'(e.code));
        chk(e.tag, "ce", 32'(ce_o), 32'(e.ce));
        chk(e.tag, "exl/erl/bev", {29'd0, exl_o, erl_o, bev_o}, {29'd0, e.exl, e.erl, e.bev});
        chk(e.tag, "sr/nmi", {30'd0, sr_o, nmi_o}, {30'd0, e.sr, e.nmi});
        chk(e.tag, "kernel R2", 32'(kernel_o), 32'd1);
        chk(e.tag, "debug mode", 32'(dm_o), 32'(e.dm));
        chk(e.tag, "debug cause", 32'(dc_o), 32'(e.dc));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=0", q.size());
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", 32'(done_o), 0);
    chk("R1", "handler", hpc_o, 0);
    chk("R1", "saved pcs", epc_o | eepc_o | depc_o, 0);
    chk("R1", "status", {26'd0, bd_o, exl_o, erl_o, bev_o, sr_o, nmi_o}, 0);
    chk("R1", "cause", {25'd0, code_o, ce_o}, 0);
    chk("R1", "kernel/debug", {24'd0, kernel_o, dm_o, dc_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(0, 5'd4, 0, 32'h1000, 0, 0, 0, 0, 0, 1, 32'h8000_1234, 0, 0, 0, 0, "R2 R5 general BEV");
    send(0, 5'd5, 0, 32'h2000, 1, 0, 0, 0, 0, 0, 32'h8000_1234, 0, 0, 0, 0, "R3 R5 slot ebase");
    send(0, 5'd4, 0, 32'h3002, 1, 1, 0, 0, 1, 0, 32'h8000_1234, 0, 0, 0, 0, "R3 16-bit slot");
    send(0, 5'd7, 0, 32'h4000, 0, 0, 0, 1, 0, 0, 32'h8000_1234, 0, 0, 0, 0, "R4 nested EXL");
    send(0, 5'd2, 0, 32'h5000, 0, 0, 1, 0, 0, 0, 32'h9000_0000, 0, 0, 0, 0, "R6 refill EXL clear");
    send(0, 5'd3, 0, 32'h5004, 0, 0, 1, 1, 0, 0, 32'h9000_0000, 0, 0, 0, 0, "R6 R4 refill EXL set");
    send(0, 5'd11, 2, 32'h5100, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8 CE written");
    send(0, 5'd10, 3, 32'h5200, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8 CE kept");
    send(1, 5'd9, 0, 32'h6000, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 0, 0, 0, 8'h01, "R7 IV clear");
    send(1, 5'd9, 0, 32'h6004, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 1, 0, 5'd2, 8'h29, "R7 IV plain");
    send(1, 5'd9, 0, 32'h6008, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 1, 1, 5'd2, 8'h29, "R7 vectored");
    send(1, 5'd9, 0, 32'h600C, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 1, 1, 5'd31, 8'h80, "R7 max spacing");
    send(1, 5'd9, 0, 32'h6010, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 1, 1, 5'd4, 8'h00, "R7 none pending");
    send(1, 5'd9, 0, 32'h6014, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 1, 1, 5'd0, 8'h10, "R7 zero spacing");
    send(2, 0, 0, 32'h7000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 cold reset");
    send(3, 0, 0, 32'h7100, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R9 soft reset");
    send(4, 0, 0, 32'h7202, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 R3 NMI");
    send(0, 5'd4, 0, 32'h7300, 1, 0, 0, 0, 0, 0, 32'h8000_0000, 0, 0, 0, 0, "R2 set bd");
    send(5, 0, 0, 32'h8000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 single step");
    send(8, 0, 0, 32'h8102, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R10 break slot");
    send(10, 0, 0, 32'h8200, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R10 data load");

    // R11 quiet when idle
    held = hpc_o;
    kind = 4'd0; pc = 32'hDEAD_0000; bev = 1;
    repeat (4) @(negedge clk);
    chk("R11", "no done while idle", 32'(done_o), 0);
    chk("R11", "handler held", hpc_o, held);
    chk("R11", "all results consumed", 32'(q.size()), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule